// File: doc/BRIEF.md
# Programmable 16x Baud Tick Generator

This block produces the 16x oversampling enable that paces a UART's serial engines. A reference clock is first divided by a software-chosen prescale of 1 or 4. The prescaled steps are then counted down by a 16-bit divisor. Every time the count runs out, the block emits a one-clock pulse on `gen_tick_o`. That pulse is the 16x rate and can be routed off the block like any other output. With a 24 MHz reference, prescale 1 and divisor 1, the 16x pulse arrives on every reference clock, which gives the fastest bit rate of 1.5 Mbps.

The receive side does not take its timing from the generator. It takes it from a separate tick input, `rx_ref_tick_i`, and re-times that input onto `rx_tick_o`. To run the receiver at the generator's rate, connect `gen_tick_o` back to `rx_ref_tick_i`. Otherwise, any other 16x source can drive it.

Software programs the block through a small write port with three registers: the divisor low byte, the divisor high byte and a prescale-select bit. A new divisor only takes effect at the next reload of the counter, so a running period is never cut short.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `gen_tick_o` and `rx_tick_o` are low. Reset sets the divisor to the parameter `DIV_RESET` (default 3) and selects prescale 1. The first `gen_tick_o` pulse follows the `DIV_RESET`-th rising edge after reset is released.
- R2: Writing address 2 sets the prescale from `wr_data[0]`: 0 selects divide-by-1 and 1 selects divide-by-4. Pulses then repeat every P×D clocks, where P is the prescale and D is the divisor.
- R3: Address 0 writes bits 7:0 of the divisor and address 1 writes bits 15:8. A write to address 3 changes nothing at the outputs.
- R4: A divisor write takes effect only at the next reload. The period in progress completes with the divisor loaded at its start.
- R5: Each period yields exactly one single-clock pulse.
- R6: A divisor of 0 stops the pulses once the current period has ended. When a nonzero divisor is then written, the counter loads it on the following edge, and the first pulse comes P×D clocks after that load.
- R7: Changing the prescale select restarts the prescale phase. After the change, the first prescaled step falls P clocks after the change edge, so no short step occurs. Writing the same value again does not restart the phase.
- R8: `rx_tick_o` equals `rx_ref_tick_i` delayed by one clock, whatever the divisor and prescale settings.
- R9: With prescale 1 and divisor 1, `gen_tick_o` is high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 prescale select, 3 unused |
| wr_data | input | 8 | Write data |
| rx_ref_tick_i | input | 1 | External 16x tick for the receive side |
| gen_tick_o | output | 1 | Generated 16x tick pulse |
| rx_tick_o | output | 1 | Re-timed receive 16x tick |

## Verification
The generator pulse is registered. It appears in the cycle after the edge on which the count expires: the P×D-th edge after a reload, after reset release, or after the edge that loads a divisor out of the stopped state. `rx_tick_o` follows its input one edge later. The bench keeps a behavioural model that updates on the same rising edge as the design and applies those latencies. It then compares both outputs at every falling edge, away from the edge that changes them. Each stimulus phase, including mid-period divisor writes and prescale changes, tags its comparisons with the requirement it exercises.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    REG_DIV_LO = 2'd0,
    REG_DIV_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_SPARE  = 2'd3
  } baud_reg_e;

endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int          DATA_W    = BYTE_W,
  parameter int unsigned DIV_RESET = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [2*DATA_W-1:0]   div_o,
  output logic                  sel_o,
  output logic                  sel_change_o
);

  localparam int DIV_W = 2 * DATA_W;

  logic [DATA_W-1:0] lo_q, hi_q;
  logic              sel_q;
  logic              wr_lo, wr_hi, wr_ctrl;

  assign wr_lo   = wr_en && (wr_addr == REG_DIV_LO);
  assign wr_hi   = wr_en && (wr_addr == REG_DIV_HI);
  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= DATA_W'(DIV_RESET);
      hi_q  <= DATA_W'(DIV_RESET >> DATA_W);
      sel_q <= 1'b0;
    end else begin
      if (wr_lo)   lo_q  <= wr_data;
      if (wr_hi)   hi_q  <= wr_data;
      if (wr_ctrl) sel_q <= wr_data[0];
    end
  end

  assign div_o        = {hi_q, lo_q};
  assign sel_o        = sel_q;
  assign sel_change_o = wr_ctrl && (wr_data[0] != sel_q);

  // R3: the divisor only moves on a write to one of its byte addresses
  p_divisor_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_lo || wr_hi) |=> (div_o == $past(div_o)));

  logic unused_w;
  assign unused_w = ^{DIV_W};

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PRE_FACTOR = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel_i,
  input  logic                          restart_i,
  output logic                          step_o,
  output logic [$clog2(PRE_FACTOR)-1:0] phase_o
);

  localparam int PW = $clog2(PRE_FACTOR);
  localparam logic [PW-1:0] LAST = PW'(PRE_FACTOR - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;

  assign limit  = sel_i ? LAST : '0;
  assign step_o = (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (restart_i || step_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = cnt_q;

  // R2: in divide-by-4 mode prescaled steps are never back to back
  p_pre_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_i && step_o) |=> !(sel_i && step_o));

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int          DIV_W     = 16,
  parameter int unsigned DIV_RESET = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             start_o,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] count_q;
  logic             tick_q;
  logic             idle;

  assign idle    = (count_q == '0);
  assign start_o = idle && (div_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= DIV_W'(DIV_RESET);
      tick_q  <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (idle) begin
        if (start_o) count_q <= div_i;
      end else if (step_i) begin
        if (count_q == ONE) begin
          tick_q  <= 1'b1;
          count_q <= div_i;
        end else begin
          count_q <= count_q - ONE;
        end
      end
    end
  end

  assign tick_o = tick_q;

  // R6: a stopped counter with a zero divisor stays silent
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (idle && div_i == '0) |=> !tick_o);

  // R4: every pulse coincides with a reload from the divisor present at that edge
  p_tick_reload_r4: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (count_q == $past(div_i)));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int          DATA_W     = BYTE_W,
  parameter int          PRE_FACTOR = 4,
  parameter int unsigned DIV_RESET  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_ref_tick_i,
  output logic              gen_tick_o,
  output logic              rx_tick_o
);

  localparam int DIV_W = 2 * DATA_W;
  localparam int PW    = $clog2(PRE_FACTOR);

  logic [DIV_W-1:0] div_val;
  logic             pre_sel;
  logic             sel_change;
  logic             pre_step;
  logic [PW-1:0]    pre_phase;
  logic             div_start;
  logic             rx_q;

  baud_regs #(.DATA_W(DATA_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .div_o(div_val), .sel_o(pre_sel), .sel_change_o(sel_change)
  );

  baud_prescaler #(.PRE_FACTOR(PRE_FACTOR)) u_pre (
    .clk(clk), .rst(rst), .sel_i(pre_sel), .restart_i(sel_change || div_start),
    .step_o(pre_step), .phase_o(pre_phase)
  );

  baud_divider #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_div (
    .clk(clk), .rst(rst), .step_i(pre_step), .div_i(div_val),
    .start_o(div_start), .tick_o(gen_tick_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_q <= 1'b0;
    else     rx_q <= rx_ref_tick_i;
  end
  assign rx_tick_o = rx_q;

  // R7: a change of prescale select leaves the prescale phase at zero
  p_sel_restart_r7: assert property (@(posedge clk) disable iff (rst)
    sel_change |=> (pre_phase == '0));

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  localparam int DIV_RESET = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rx_ref_tick_i = 1'b0;
  logic       gen_tick_o, rx_tick_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_div = DIV_RESET, m_p4 = 0, m_pc = 0, m_dc = DIV_RESET;
  bit m_tick = 0, m_rx = 0;

  baud_tick_gen #(.DIV_RESET(DIV_RESET)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_ref_tick_i(rx_ref_tick_i), .gen_tick_o(gen_tick_o), .rx_tick_o(rx_tick_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    int per, npc, ndc;
    bit pp, nt;
    if (rst) begin
      m_div = DIV_RESET; m_p4 = 0; m_pc = 0; m_dc = DIV_RESET; m_tick = 0; m_rx = 0;
    end else begin
      per = m_p4 ? 4 : 1;
      pp  = (m_pc == per - 1);
      npc = pp ? 0 : m_pc + 1;
      ndc = m_dc;
      nt  = 0;
      if (m_dc == 0) begin
        if (m_div != 0) begin ndc = m_div; npc = 0; end
      end else if (pp) begin
        if (m_dc == 1) begin nt = 1; ndc = m_div; end
        else ndc = m_dc - 1;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_div = (m_div & 16'hFF00) | int'(wr_data);
          2'd1: m_div = (m_div & 16'h00FF) | (int'(wr_data) << 8);
          2'd2: if (int'(wr_data[0]) != m_p4) begin m_p4 = int'(wr_data[0]); npc = 0; end
          default: ;
        endcase
      end
      m_pc = npc; m_dc = ndc; m_tick = nt; m_rx = rx_ref_tick_i;
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(cur_req, gen_tick_o, m_tick, "gen_tick_o");
      check("R8", rx_tick_o, m_rx, "rx_tick_o");
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rx_ref_tick_i = lfsr[0];
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    run(4);
    check("R1", gen_tick_o, 1'b0, "gen_tick_o in reset");
    check("R1", rx_tick_o, 1'b0, "rx_tick_o in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", gen_tick_o, 1'b0, "gen_tick_o first cycle");
    check("R1", rx_tick_o, 1'b0, "rx_tick_o first cycle");
    cur_req = "R1"; run(20);
    cur_req = "R4"; run(1); wr(2'd0, 8'd5); run(40);
    cur_req = "R7"; wr(2'd2, 8'd1); run(60);
    cur_req = "R7"; run(2); wr(2'd2, 8'd1); run(30);
    cur_req = "R2"; run(1); wr(2'd2, 8'd0); run(3); wr(2'd2, 8'd1); run(50);
    cur_req = "R3"; wr(2'd1, 8'd1); run(2200);
    cur_req = "R3"; wr(2'd1, 8'd0); run(100); wr(2'd3, 8'hFF); run(60);
    cur_req = "R6"; wr(2'd0, 8'd0); run(60);
    cur_req = "R6"; wr(2'd0, 8'd2); run(40);
    cur_req = "R5"; wr(2'd2, 8'd0); run(30);
    cur_req = "R9"; wr(2'd0, 8'd1); run(30);
    cur_req = "R4"; wr(2'd0, 8'd7); run(2); wr(2'd0, 8'd2); run(40);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule